// File: doc/BRIEF.md
# Readback Signature Upset Monitor

After configuration finishes, this block watches the configuration memory for single-event upsets. A readback engine, outside this block, scans the memory and presents the contents as a stream of 32-bit words. Each scan opens with a start marker and closes with an end marker. The monitor folds every word of a scan into a 32-bit CRC. At the end of each scan it stores the result in a readback-signature register and compares it against an expected signature that was computed beforehand.

A mismatch raises a sticky internal error output. The block can also report the error on a shared open-drain status pin, which it pulls low on error.

The status pin has two roles. Until configuration is done, it carries whatever drive the configuration logic requests. Once configuration is done and detection is enabled, the monitor owns the pin. The pin then shows the error when the pin-flag control is set, or stays released when that flag is clear. While detection is enabled, a user request to drive the pin is always blocked. When detection is disabled after configuration, the pin passes through to user logic.

Top module: `rbm_upset_mon`

## Requirements
- R1: After reset, `crc_err_o` is 0 and `rb_sig_o` is 0.
- R2: One cycle after a word that carries the end marker is taken, `rb_sig_o` equals the scan's CRC. The CRC uses polynomial 0x04C11DB7 and an initial value of 0xFFFFFFFF. Each word is shifted in MSB first, with no reflection and no final inversion. The CRC covers the words from the most recent start marker through that end word.
- R3: When a scan's CRC differs from `exp_sig_i`, `crc_err_o` is 1 in the following cycle. A matching scan never sets it.
- R4: Once set, `crc_err_o` stays at 1 through later scans, including matching ones, for as long as `det_en_i` is 1.
- R5: When `det_en_i` is 0, `crc_err_o` is 0 from the next cycle on. While disabled, words are ignored, no comparison is made and `rb_sig_o` holds its value.
- R6: When `cfg_done_i`=1, `det_en_i`=1 and `pin_flag_i`=1, `stat_pin_lo_o` equals `crc_err_o`. A value of 1 means drive low; 0 means release.
- R7: When `cfg_done_i`=1, `det_en_i`=1 and `pin_flag_i`=0, `stat_pin_lo_o` is 0 even if an error is present.
- R8: While `cfg_done_i`=0, `stat_pin_lo_o` follows `cfg_pin_lo_i`. Readback words are ignored, so neither the error nor the signature changes.
- R9: `user_pin_lo_i` has no effect while `cfg_done_i`=1 and `det_en_i`=1. When `cfg_done_i`=1 and `det_en_i`=0, `stat_pin_lo_o` follows it.
- R10: A start marker in the middle of a scan discards the partial CRC and restarts from the initial value with that word.
- R11: A word that carries both the start and the end marker forms a complete one-word scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done_i | input | 1 | Configuration complete |
| det_en_i | input | 1 | Upset detection enable |
| pin_flag_i | input | 1 | Report errors on the status pin |
| exp_sig_i | input | 32 | Expected scan signature |
| rb_valid_i | input | 1 | Readback word valid |
| rb_start_i | input | 1 | Word is the first of a scan |
| rb_end_i | input | 1 | Word is the last of a scan |
| rb_word_i | input | 32 | Readback word |
| cfg_pin_lo_i | input | 1 | Configuration logic request to pull the status pin low |
| user_pin_lo_i | input | 1 | User request to pull the status pin low |
| crc_err_o | output | 1 | Sticky upset error |
| stat_pin_lo_o | output | 1 | Open-drain enable for the status pin: 1 pulls low, 0 releases |
| rb_sig_o | output | 32 | Last computed readback signature |

## Verification
Directed scans of three words, one word, and a scan restarted in the middle check the CRC framing. A corrupted scan is followed by a clean one to show that the error is sticky. Toggling the pin flag, detection enable and configuration-done flag separates the three owners of the status pin. Random scans of 1 to 6 words use random words, random pin-flag settings and an expected signature that is right about three times in four. Occasional disables are mixed in, so together they test the compare, the error latch, the disable clear and the pin mux against one another.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [CRC_W-1:0] run;
        logic [CRC_W-1:0] sig;
    } acc_st_t;

    typedef struct packed {
        logic err;
    } err_st_t;
endpackage

// File: rtl/rbm_crc_acc.sv
module rbm_crc_acc
    import rbm_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY,
    parameter logic [CRC_W-1:0] INIT = CRC_INIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             valid_i,
    input  logic             start_i,
    input  logic             end_i,
    input  logic [CRC_W-1:0] word_i,
    input  logic [CRC_W-1:0] exp_i,
    output logic             fire_o,
    output logic             mismatch_o,
    output logic [CRC_W-1:0] sig_o
);
    acc_st_t          st_d, st_q;
    logic [CRC_W-1:0] base, nxt;
    logic             take;

    function automatic logic [CRC_W-1:0] step(input logic [CRC_W-1:0] c,
                                              input logic [CRC_W-1:0] w);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = CRC_W-1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ w[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    always_comb begin
        st_d       = st_q;
        take       = active_i & valid_i;
        base       = start_i ? INIT : st_q.run;
        nxt        = step(base, word_i);
        fire_o     = take & end_i;
        mismatch_o = (nxt != exp_i);
        if (take) begin
            st_d.run = nxt;
            if (end_i) st_d.sig = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run <= INIT;
            st_q.sig <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sig_o = st_q.sig;

    a_r2_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_o |=> $stable(sig_o));
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> $stable(sig_o));
endmodule

// File: rtl/rbm_err_ctl.sv
module rbm_err_ctl
    import rbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic det_en_i,
    input  logic fire_i,
    input  logic mismatch_i,
    output logic err_o
);
    err_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!det_en_i)                st_d.err = 1'b0;
        else if (fire_i && mismatch_i) st_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    a_r3_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && mismatch_i) |=> err_o);
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !(fire_i && mismatch_i)) |=> !err_o);
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && det_en_i) |=> err_o);
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en_i |=> !err_o);
endmodule

// File: rtl/rbm_pin_mux.sv
module rbm_pin_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_done_i,
    input  logic det_en_i,
    input  logic pin_flag_i,
    input  logic err_i,
    input  logic cfg_pin_lo_i,
    input  logic user_pin_lo_i,
    output logic pin_lo_o
);
    always_comb begin
        if (!cfg_done_i)   pin_lo_o = cfg_pin_lo_i;
        else if (det_en_i) pin_lo_o = pin_flag_i & err_i;
        else               pin_lo_o = user_pin_lo_i;
    end

    a_r6_pin_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done_i && det_en_i && pin_flag_i) |-> (pin_lo_o == err_i));
    a_r7_pin_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done_i && det_en_i && !pin_flag_i) |-> !pin_lo_o);
    a_r8_cfg_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done_i |-> (pin_lo_o == cfg_pin_lo_i));
    a_r9_user_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done_i && det_en_i && !err_i) |-> !pin_lo_o);
endmodule

// File: rtl/rbm_upset_mon.sv
module rbm_upset_mon
    import rbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done_i,
    input  logic             det_en_i,
    input  logic             pin_flag_i,
    input  logic [CRC_W-1:0] exp_sig_i,
    input  logic             rb_valid_i,
    input  logic             rb_start_i,
    input  logic             rb_end_i,
    input  logic [CRC_W-1:0] rb_word_i,
    input  logic             cfg_pin_lo_i,
    input  logic             user_pin_lo_i,
    output logic             crc_err_o,
    output logic             stat_pin_lo_o,
    output logic [CRC_W-1:0] rb_sig_o
);
    logic active, fire, mismatch;

    assign active = cfg_done_i & det_en_i;

    rbm_crc_acc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_acc (
        .clk(clk), .rst_n(rst_n), .active_i(active), .valid_i(rb_valid_i),
        .start_i(rb_start_i), .end_i(rb_end_i), .word_i(rb_word_i),
        .exp_i(exp_sig_i), .fire_o(fire), .mismatch_o(mismatch), .sig_o(rb_sig_o)
    );

    rbm_err_ctl u_err (
        .clk(clk), .rst_n(rst_n), .det_en_i(det_en_i), .fire_i(fire),
        .mismatch_i(mismatch), .err_o(crc_err_o)
    );

    rbm_pin_mux u_pin (
        .clk(clk), .rst_n(rst_n), .cfg_done_i(cfg_done_i), .det_en_i(det_en_i),
        .pin_flag_i(pin_flag_i), .err_i(crc_err_o), .cfg_pin_lo_i(cfg_pin_lo_i),
        .user_pin_lo_i(user_pin_lo_i), .pin_lo_o(stat_pin_lo_o)
    );

    a_r8_no_err_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_done_i && !crc_err_o) |=> !crc_err_o);
endmodule

// File: tb/rbm_upset_mon_tb_top.sv
`timescale 1ns/1ps
module rbm_upset_mon_tb_top;
    logic        clk = 0, rst_n = 0;
    logic        cfg_done = 0, det_en = 1, pin_flag = 1;
    logic [31:0] exp_sig = 0, word = 0;
    logic        valid = 0, st = 0, en = 0, cfg_lo = 0, user_lo = 0;
    logic        err, pin;
    logic [31:0] sig;

    int n_chk = 0, n_bad = 0;
    logic        m_err = 0;
    logic [31:0] m_sig = 0, m_crc = 32'hFFFF_FFFF;

    always #2.5 clk = ~clk;

    rbm_upset_mon dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_done_i(cfg_done), .det_en_i(det_en),
        .pin_flag_i(pin_flag), .exp_sig_i(exp_sig), .rb_valid_i(valid),
        .rb_start_i(st), .rb_end_i(en), .rb_word_i(word), .cfg_pin_lo_i(cfg_lo),
        .user_pin_lo_i(user_lo), .crc_err_o(err), .stat_pin_lo_o(pin), .rb_sig_o(sig)
    );

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] w);
        logic [31:0] r = c;
        for (int i = 31; i >= 0; i--) begin
            logic fb = r[31] ^ w[i];
            r = {r[30:0], 1'b0};
            if (fb) r ^= 32'h04C1_1DB7;
        end
        return r;
    endfunction

    function automatic logic pin_model();
        if (!cfg_done) return cfg_lo;
        if (det_en)    return pin_flag & m_err;
        return user_lo;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " err"}, {31'b0, err}, {31'b0, m_err});
        chk({req, " sig"}, sig, m_sig);
        chk({req, " pin"}, {31'b0, pin}, {31'b0, pin_model()});
    endtask

    // drive one word at negedge; outputs checked at the following negedge
    task automatic send(input logic s, input logic e, input logic [31:0] w);
        valid = 1; st = s; en = e; word = w;
        @(negedge clk);
        valid = 0; st = 0; en = 0;
        if (cfg_done && det_en) begin
            m_crc = crc_step(s ? 32'hFFFF_FFFF : m_crc, w);
            if (e) begin
                m_sig = m_crc;
                if (m_crc != exp_sig) m_err = 1;
            end
        end
    endtask

    function automatic logic [31:0] scan_crc(input logic [31:0] a[], input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) c = crc_step(c, a[i]);
        return c;
    endfunction

    task automatic run_scan(input int n, input bit good, input string req);
        logic [31:0] a[];
        a = new[n];
        for (int i = 0; i < n; i++) a[i] = $urandom;
        exp_sig = scan_crc(a, n) ^ (good ? 32'h0 : (32'h1 << ($urandom % 32)));
        for (int i = 0; i < n; i++) send(i == 0, i == n - 1, a[i]);
        check_all(req);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1 reset");
        cfg_lo = 1; #0.1;
        chk("R8 cfg pass", {31'b0, pin}, 32'd1);
        run_scan(3, 0, "R8 ignored during cfg");
        cfg_lo = 0;
        cfg_done = 1; user_lo = 1;
        @(negedge clk);
        run_scan(3, 1, "R2 R3 three-word match");
        chk("R9 user blocked", {31'b0, pin}, 32'd0);
        run_scan(1, 1, "R11 single word");
        begin
            logic [31:0] a2[];
            a2 = new[2];
            a2[0] = 32'hDEAD_BEEF; a2[1] = 32'h0000_0001;
            exp_sig = scan_crc(a2, 2);
            send(1, 0, 32'h1234_5678); send(0, 0, 32'hCAFE_F00D);
            send(1, 0, a2[0]); send(0, 1, a2[1]);
            check_all("R10 restart");
            chk("R10 no err", {31'b0, err}, 32'd0);
        end
        run_scan(4, 0, "R3 mismatch");
        chk("R3 err set", {31'b0, err}, 32'd1);
        chk("R6 pin low", {31'b0, pin}, 32'd1);
        run_scan(2, 1, "R4 sticky");
        chk("R4 err held", {31'b0, err}, 32'd1);
        pin_flag = 0; #0.1;
        chk("R7 released", {31'b0, pin}, 32'd0);
        pin_flag = 1;
        det_en = 0; user_lo = 0;
        @(negedge clk); m_err = 0;
        check_all("R5 clear");
        run_scan(3, 0, "R5 ignored");
        user_lo = 1; #0.1;
        chk("R9 user passes", {31'b0, pin}, 32'd1);
        det_en = 1;
        @(negedge clk);
        for (int k = 0; k < 60; k++) begin
            pin_flag = $urandom % 2;
            user_lo  = $urandom % 2;
            if ($urandom % 8 == 0) begin
                det_en = 0; @(negedge clk); m_err = 0;
                check_all("R5 random disable");
                det_en = 1;
            end
            run_scan(1 + $urandom % 6, ($urandom % 4) != 0, "R2 R3 R4 R6 R7 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule